// File: doc/BRIEF.md
# Guarded Reference Clock Source Switcher

This block produces a high-frequency reference clock from one of two oscillator clocks, an external one and an internal one. The change of source is glitch-free. Each source has a gate that opens only after the other gate has closed. Every gate changes on a falling edge of its own clock, so the output never shows a short pulse. Control comes from a small set of fields written over a single-cycle write port. The write port and all control logic run on a free-running control clock `clk`, and one machine cycle is a fixed number of `clk` periods.

The block also checks the software sequence around the switch. A guarded write asserts a one-cycle system-clock-reset pulse and puts every field back to its reset value. Four writes are guarded: stopping the oscillator that is selected, stopping the external oscillator while a switch is busy, stopping it within two machine cycles of a select change, and starting it while its pin is not assigned to the oscillator function. An external warm-up counter gets a start pulse whenever an oscillator enable rises. It answers with a done input. A change of source waits until that warm-up is done.

Top module: `refclk_switch`

## Requirements
- R1: After `rst`, `ext_osc_en`=1, `int_osc_en`=0, `slow_mode`=0, `switch_busy`=0 and `sys_rst`=0, and `ref_clk` follows `ext_clk`.
- R2: A write (`wr_en`=1 for one `clk` cycle) takes `wr_data` bit 0 as internal enable, bit 1 as source select (1 = internal), bit 2 as external enable and bit 3 as slow flag. `int_osc_en`, `ext_osc_en` and `slow_mode` show the new values from the next `clk` edge.
- R3: While the stored slow flag is 1, the select bit of a write is ignored. The selected source stays as it was and `switch_busy` stays 0.
- R4: The two source gates are never open together. No `ref_clk` high or low phase is shorter than the shorter source half period. No low phase exceeds three external plus three internal periods.
- R5: After a select change to internal with no warm-up pending, `switch_busy` falls within 60 `clk` cycles and `ref_clk` then follows `int_clk`.
- R6: `switch_busy` is 1 two `clk` edges after the write that changes the select bit, and stays 1 until the new source's gate is open.
- R7: A write that clears the external enable while `switch_busy` is 1 asserts `sys_rst`.
- R8: A write that clears the external enable fewer than 2×MC_CLKS `clk` cycles after an accepted select change asserts `sys_rst`. The same write later, with internal selected and not busy, is accepted.
- R9: A write that sets the external enable while `pin_ext_fn`=0 asserts `sys_rst`.
- R10: A write that clears the enable of the selected source asserts `sys_rst`.
- R11: `sys_rst` is a one-cycle pulse on the edge after the guarded write. That write is not applied, and every field returns to its reset value (external selected and enabled).
- R12: `warm_start` pulses for one cycle after a write that raises either oscillator enable. Writing 1 to an enable that is already 1 gives no pulse.
- R13: After `warm_start`, a select change is held back until `warm_done` has been seen. Meanwhile `switch_busy` is 1 and `ref_clk` stays on the old source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock; one machine cycle is MC_CLKS of its periods |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External oscillator clock |
| int_clk | input | 1 | Internal oscillator clock |
| wr_en | input | 1 | Field write strobe |
| wr_data | input | 4 | Field values: bit0 internal enable, bit1 select, bit2 external enable, bit3 slow |
| pin_ext_fn | input | 1 | 1 when the external clock pin is assigned to the oscillator |
| warm_done | input | 1 | Warm-up counter finished |
| ref_clk | output | 1 | Gated reference clock |
| ext_osc_en | output | 1 | External oscillator enable field |
| int_osc_en | output | 1 | Internal oscillator enable field |
| slow_mode | output | 1 | Slow flag field |
| warm_start | output | 1 | One-cycle warm-up start pulse |
| switch_busy | output | 1 | Source change under way |
| sys_rst | output | 1 | One-cycle system clock reset pulse |

## Verification
A wrong field or guard-counter value shows at the ports on the first `clk` edge after the next write. It appears as a missing or extra `sys_rst` pulse, a wrong `warm_start`, or enable outputs that differ from the value written. A reference model checks these signals every cycle. A stuck gate or a wrong handshake between the two clock domains appears as `switch_busy` that never falls, or that falls while `ref_clk` still counts edges at the old source's rate. It can also appear as a short or overlong `ref_clk` phase, which an edge-timing monitor records within one source period.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  localparam int FIELD_W = 4;
  localparam int NUM_SRC = 2;
  localparam int SRC_EXT = 0;
  localparam int SRC_INT = 1;

  // bit3 slow, bit2 external enable, bit1 select internal, bit0 internal enable
  typedef struct packed {
    logic slow;
    logic ext_en;
    logic sel_int;
    logic int_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{slow: 1'b0, ext_en: 1'b1, sel_int: 1'b0, int_en: 1'b0};
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate #(
  parameter int SYNC_STAGES = 2,
  parameter bit GATE_INIT   = 1'b0
) (
  input  logic src_clk,
  input  logic rst,
  input  logic req,
  output logic gate_o
);
  logic req_s;
  logic gate_q;

  // request crosses into the source domain first
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(GATE_INIT)) u_req_sync (
    .clk(src_clk), .rst(rst), .d(req), .q(req_s)
  );

  // gate only moves while its clock is low, so no partial pulse escapes
  always_ff @(negedge src_clk) begin
    if (rst) gate_q <= GATE_INIT;
    else     gate_q <= req_s;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int MC_CLKS     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               pin_ext_fn,
  input  logic               warm_done,
  input  logic               ext_gate,
  input  logic               int_gate,
  output logic               sel_go_o,
  output ctrl_t              ctrl_o,
  output logic               warm_start_o,
  output logic               busy_o,
  output logic               sys_rst_o
);
  localparam int GUARD = 2 * MC_CLKS;
  localparam int GW    = $clog2(GUARD + 1);

  ctrl_t          cur_q;
  ctrl_t          wr;
  logic [GW-1:0]  guard_q, guard_next;
  logic           sel_next, viol, ws_next;
  logic           warming_q, warming_next;
  logic           sel_go_q, busy_q, busy_next;
  logic           sys_rst_q, warm_start_q;
  logic           ext_on_s, int_on_s;
  logic           stop_ext_bad, start_ext_bad, stop_int_bad;

  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_on_sync (
    .clk(clk), .rst(rst), .d(ext_gate), .q(ext_on_s)
  );
  clksw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_int_on_sync (
    .clk(clk), .rst(rst), .d(int_gate), .q(int_on_s)
  );

  assign wr = ctrl_t'(wr_data);

  always_comb begin
    stop_ext_bad  = cur_q.ext_en & ~wr.ext_en &
                    (~cur_q.sel_int | busy_q | (guard_q != '0));
    start_ext_bad = ~cur_q.ext_en & wr.ext_en & ~pin_ext_fn;
    stop_int_bad  = cur_q.int_en & ~wr.int_en & (cur_q.sel_int | busy_q);
    viol          = wr_en & (stop_ext_bad | start_ext_bad | stop_int_bad);
    sel_next      = cur_q.slow ? cur_q.sel_int : wr.sel_int;
    ws_next       = wr_en & ~viol &
                    ((wr.int_en & ~cur_q.int_en) | (wr.ext_en & ~cur_q.ext_en));
    if (wr_en && (sel_next != cur_q.sel_int)) guard_next = GW'(GUARD);
    else if (guard_q != '0)                   guard_next = guard_q - GW'(1);
    else                                      guard_next = '0;
    warming_next  = ws_next | (warming_q & ~warm_done);
    busy_next     = (cur_q.sel_int != sel_go_q) | (sel_go_q ? ~int_on_s : ~ext_on_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q        <= CTRL_RST;
      guard_q      <= '0;
      sys_rst_q    <= 1'b0;
      warm_start_q <= 1'b0;
      warming_q    <= 1'b0;
      sel_go_q     <= 1'b0;
      busy_q       <= 1'b0;
    end else begin
      sys_rst_q <= viol;
      busy_q    <= busy_next;
      if (viol) begin
        cur_q        <= CTRL_RST;
        guard_q      <= '0;
        warm_start_q <= 1'b0;
        warming_q    <= 1'b0;
        sel_go_q     <= 1'b0;
      end else begin
        if (wr_en) cur_q <= '{slow: wr.slow, ext_en: wr.ext_en,
                              sel_int: sel_next, int_en: wr.int_en};
        guard_q      <= guard_next;
        warm_start_q <= ws_next;
        warming_q    <= warming_next;
        if (!warming_q) sel_go_q <= cur_q.sel_int;
      end
    end
  end

  assign sel_go_o     = sel_go_q;
  assign ctrl_o       = cur_q;
  assign warm_start_o = warm_start_q;
  assign busy_o       = busy_q;
  assign sys_rst_o    = sys_rst_q;

  a_r3_sel_held_slow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_q.slow && !viol) |=> (cur_q.sel_int == $past(cur_q.sel_int)));
  a_r7_stop_while_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_q.ext_en && !wr.ext_en && busy_q) |=> sys_rst_q);
  a_r8_stop_in_guard: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cur_q.ext_en && !wr.ext_en && (guard_q != '0)) |=> sys_rst_q);
  a_r9_start_without_pin: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !cur_q.ext_en && wr.ext_en && !pin_ext_fn) |=> sys_rst_q);
  a_r11_fields_restored: assert property (@(posedge clk) disable iff (rst)
    sys_rst_q |-> (cur_q == CTRL_RST && !sel_go_q && !warm_start_q));
  a_r12_start_only_on_rise: assert property (@(posedge clk) disable iff (rst)
    warm_start_q |-> ($rose(cur_q.ext_en) || $rose(cur_q.int_en)));
endmodule

// File: rtl/refclk_switch.sv
`timescale 1ns/1ps
module refclk_switch
  import clksw_pkg::*;
#(
  parameter int MC_CLKS     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_clk,
  input  logic               int_clk,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               pin_ext_fn,
  input  logic               warm_done,
  output logic               ref_clk,
  output logic               ext_osc_en,
  output logic               int_osc_en,
  output logic               slow_mode,
  output logic               warm_start,
  output logic               switch_busy,
  output logic               sys_rst
);
  logic [NUM_SRC-1:0] src_clk, gate, req;
  logic               sel_go;
  ctrl_t              ctrl;

  clksw_ctrl #(.MC_CLKS(MC_CLKS), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .pin_ext_fn(pin_ext_fn), .warm_done(warm_done),
    .ext_gate(gate[SRC_EXT]), .int_gate(gate[SRC_INT]),
    .sel_go_o(sel_go), .ctrl_o(ctrl), .warm_start_o(warm_start),
    .busy_o(switch_busy), .sys_rst_o(sys_rst)
  );

  assign src_clk = {int_clk, ext_clk};

  // each side asks for its gate only once the other gate reads closed
  assign req[SRC_EXT] = ~sel_go & ~gate[SRC_INT];
  assign req[SRC_INT] =  sel_go & ~gate[SRC_EXT];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    clksw_gate #(.SYNC_STAGES(SYNC_STAGES), .GATE_INIT(g == SRC_EXT)) u_gate (
      .src_clk(src_clk[g]), .rst(rst), .req(req[g]), .gate_o(gate[g])
    );
  end

  assign ref_clk    = |(src_clk & gate);
  assign ext_osc_en = ctrl.ext_en;
  assign int_osc_en = ctrl.int_en;
  assign slow_mode  = ctrl.slow;

  a_r4_gates_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate[SRC_EXT] && gate[SRC_INT]));
endmodule

// File: tb/test_refclk_switch.sv
`timescale 1ns/1ps
module test_refclk_switch;
  localparam int MC    = 16;
  localparam int GUARD = 2 * MC;
  localparam realtime T_EXT = 14.0;
  localparam realtime T_INT = 22.0;

  logic clk = 0, ext_clk = 0, int_clk = 0;
  logic rst, wr_en, pin_ext_fn, warm_done;
  logic [3:0] wr_data;
  logic ref_clk, ext_osc_en, int_osc_en, slow_mode, warm_start, switch_busy, sys_rst;

  int errs = 0, checks = 0;

  always #5   clk = ~clk;
  always #7   ext_clk = ~ext_clk;
  always #11  int_clk = ~int_clk;

  refclk_switch #(.MC_CLKS(MC)) i_refclk_switch (
    .clk(clk), .rst(rst), .ext_clk(ext_clk), .int_clk(int_clk),
    .wr_en(wr_en), .wr_data(wr_data), .pin_ext_fn(pin_ext_fn), .warm_done(warm_done),
    .ref_clk(ref_clk), .ext_osc_en(ext_osc_en), .int_osc_en(int_osc_en),
    .slow_mode(slow_mode), .warm_start(warm_start), .switch_busy(switch_busy),
    .sys_rst(sys_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference for the control-clock outputs
  bit m_int, m_ext, m_sel, m_slow, m_ws, m_rst, busy_seen, bad, nsel;
  int m_guard;
  always @(posedge clk) begin
    if (rst) begin
      m_int = 0; m_ext = 1; m_sel = 0; m_slow = 0; m_ws = 0; m_rst = 0; m_guard = 0;
    end else begin
      bad = 0;
      if (wr_en) begin
        if (m_ext && !wr_data[2] && (!m_sel || busy_seen || m_guard > 0)) bad = 1;
        if (!m_ext && wr_data[2] && !pin_ext_fn) bad = 1;
        if (m_int && !wr_data[0] && (m_sel || busy_seen)) bad = 1;
      end
      if (bad) begin
        m_int = 0; m_ext = 1; m_sel = 0; m_slow = 0; m_ws = 0; m_guard = 0; m_rst = 1;
      end else begin
        m_rst = 0;
        if (wr_en) begin
          nsel = m_slow ? m_sel : wr_data[1];
          m_ws = (wr_data[0] && !m_int) || (wr_data[2] && !m_ext);
          if (nsel != m_sel) m_guard = GUARD;
          else if (m_guard > 0) m_guard--;
          m_int = wr_data[0]; m_ext = wr_data[2]; m_slow = wr_data[3]; m_sel = nsel;
        end else begin
          m_ws = 0;
          if (m_guard > 0) m_guard--;
        end
      end
    end
  end

  always @(negedge clk) begin
    busy_seen = switch_busy;
    if (!rst) begin
      chk(ext_osc_en == m_ext,  "R2 ext_osc_en", ext_osc_en, m_ext);
      chk(int_osc_en == m_int,  "R2 int_osc_en", int_osc_en, m_int);
      chk(slow_mode == m_slow,  "R2 slow_mode",  slow_mode,  m_slow);
      chk(warm_start == m_ws,   "R12 warm_start", warm_start, m_ws);
      chk(sys_rst == m_rst,     "R11 sys_rst",    sys_rst,    m_rst);
    end
  end

  // edge counters and phase monitor
  int ref_cnt = 0, ext_cnt = 0, int_cnt = 0;
  always @(posedge ref_clk) ref_cnt++;
  always @(posedge ext_clk) ext_cnt++;
  always @(posedge int_clk) int_cnt++;

  bit armed = 0;
  realtime last_t = 0.0, min_phase = 1.0e9, max_low = 0.0;
  always @(ref_clk) begin
    if (armed && last_t > 0.0) begin
      if ($realtime - last_t < min_phase) min_phase = $realtime - last_t;
      if (ref_clk && ($realtime - last_t > max_low)) max_low = $realtime - last_t;
    end
    last_t = $realtime;
  end

  task automatic wr(input logic [3:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic follows(input bit want_int, input string req);
    int r0, e0, i0, dr, dw;
    r0 = ref_cnt; e0 = ext_cnt; i0 = int_cnt;
    #440;
    dr = ref_cnt - r0;
    dw = want_int ? (int_cnt - i0) : (ext_cnt - e0);
    chk((dr - dw <= 1) && (dw - dr <= 1), req, dr, dw);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); warm_done = 1;
    @(negedge clk); warm_done = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errs++; checks++;
    $display("FAIL R5 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int waited;
    rst = 1; wr_en = 0; wr_data = 0; pin_ext_fn = 1; warm_done = 0;
    idle(6);
    rst = 0;
    idle(2);
    armed = 1;

    // R1 reset state
    chk(switch_busy == 0, "R1 busy", switch_busy, 0);
    chk(sys_rst == 0, "R1 sys_rst", sys_rst, 0);
    chk(ext_osc_en == 1 && int_osc_en == 0 && slow_mode == 0, "R1 fields",
        {ext_osc_en, int_osc_en, slow_mode}, 3'b100);
    follows(0, "R1 ref follows ext");

    // R10 stop selected external source
    wr(4'b0000);
    chk(sys_rst == 1, "R10 stop selected", sys_rst, 1);
    @(negedge clk);
    chk(sys_rst == 0, "R11 single pulse", sys_rst, 0);
    chk(ext_osc_en == 1, "R11 ext restored", ext_osc_en, 1);

    // R12 warm-up start only on a rising enable
    wr(4'b0101);
    chk(warm_start == 1, "R12 start on rise", warm_start, 1);
    chk(int_osc_en == 1, "R2 int enable", int_osc_en, 1);
    wr(4'b0101);
    chk(warm_start == 0, "R12 no restart", warm_start, 0);

    // R3 select ignored in slow mode
    wr(4'b1101);
    wr(4'b1111);
    idle(30);
    chk(switch_busy == 0, "R3 busy", switch_busy, 0);
    chk(slow_mode == 1, "R2 slow", slow_mode, 1);
    follows(0, "R3 ref stays ext");

    // R13 switch held back while warm-up pending
    wr(4'b0101);
    wr(4'b0111);
    idle(30);
    chk(switch_busy == 1, "R13 busy while warming", switch_busy, 1);
    follows(0, "R13 ref stays ext");

    // R7 stop external while busy
    wr(4'b0011);
    chk(sys_rst == 1, "R7 stop while busy", sys_rst, 1);
    idle(40);
    chk(switch_busy == 0, "R11 busy after reset", switch_busy, 0);
    follows(0, "R11 ref back on ext");

    // R5 R6 full switch, then R8 stop inside the guard window
    wr(4'b0101);
    pulse_done();
    wr(4'b0111);
    @(negedge clk);
    chk(switch_busy == 1, "R6 busy after select", switch_busy, 1);
    waited = 0;
    while (switch_busy && waited < 60) begin @(negedge clk); waited++; end
    chk(switch_busy == 0, "R5 switch completes", waited, 60);
    wr(4'b0011);
    chk(sys_rst == 1, "R8 stop inside guard", sys_rst, 1);

    // R5 ref follows internal; R8 late stop accepted
    idle(4);
    wr(4'b0101);
    pulse_done();
    wr(4'b0111);
    waited = 0;
    while (switch_busy && waited < 60) begin @(negedge clk); waited++; end
    follows(1, "R5 ref follows int");
    wr(4'b0011);
    chk(sys_rst == 0, "R8 late stop accepted", sys_rst, 0);
    chk(ext_osc_en == 0, "R8 ext stopped", ext_osc_en, 0);
    follows(1, "R8 ref stays int");

    // R9 start external without pin function
    pin_ext_fn = 0;
    wr(4'b0111);
    chk(sys_rst == 1, "R9 start without pin", sys_rst, 1);
    pin_ext_fn = 1;
    idle(40);
    follows(0, "R11 ref back on ext");

    // R4 phase limits over the whole run
    chk(min_phase >= 6.99, "R4 min phase ps", int'(min_phase * 1000), 7000);
    chk(max_low <= 3.0 * (T_EXT + T_INT), "R4 max low ps",
        int'(max_low * 1000), int'(3.0 * (T_EXT + T_INT) * 1000));

    finish_run();
  end
endmodule